// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address sequence for one burst of a synchronous DRAM read or write. A single-cycle start pulse is sampled together with the starting 8-bit column and the decoded burst settings: a length code, an ordering select (linear wrap or XOR interleave), an access direction, and a flag that forces writes to a single beat. From the next cycle on, the block emits one column per clock with a valid strobe. A last-beat strobe marks the final column of every finite burst.

The block supports lengths of 1, 2, 4 and 8 and a free-running whole-page mode. Linear bursts count upward inside the aligned block that the length selects. Interleaved bursts XOR the beat index into the low column bits. A whole-page burst runs past column 255 back to 0 until a stop input ends it. A stop input, or a new start, ends any burst on the next clock. An illegal combination of settings produces a one-cycle error pulse and no addresses. The command sequencer around the block decodes the mode register and drives these inputs. Rows, banks and data stay outside this block.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, colValid, lastBeat and errFlag are 0 and colOut is 0x00.
- R2: A start sampled at a rising edge makes colValid 1 with colOut equal to startCol in the following cycle. Each later beat appears one clock after the previous one.
- R3: Length code lenSel selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a whole page. With interleave = 0 and a finite length N, beat k has low log2(N) bits equal to (startCol + k) mod N, and the upper bits equal those of startCol.
- R4: With interleave = 1 and lenSel 2 or 3, beat k has low log2(N) bits equal to startCol XOR k, and the upper bits equal those of startCol.
- R5: With lenSel = 7 and interleave = 0, colOut rises by one per clock, wraps from 0xFF to 0x00, and continues with lastBeat = 0 until stopped.
- R6: lastBeat is 1 exactly on the final beat of a finite burst. colValid is 0 in the cycle after that beat unless a new start was sampled.
- R7: A stop input (terminate = 1) during a valid beat, with no start present, makes colValid 0 in the next cycle.
- R8: Some combinations are illegal: lenSel 4, 5 or 6, or interleave = 1 with lenSel 0, 1 or 7. Such a start yields errFlag = 1 for exactly one cycle, emits no beat, and ends any burst in progress.
- R9: When singleWrite = 1 and isWrite = 1, a start emits one beat at startCol with lastBeat = 1, whatever lenSel and interleave hold, and raises no error. Reads with singleWrite = 1 use the programmed length.
- R10: A start during an active burst abandons it and begins the new burst in the next cycle. A start takes precedence over terminate in the same cycle.
- R11: Without a start, colValid does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled and outputs updated on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | One-cycle request to begin a burst |
| isWrite | input | 1 | 1 for a write access, 0 for a read |
| singleWrite | input | 1 | Force writes to a single beat |
| interleave | input | 1 | 0 linear wrap ordering, 1 XOR ordering |
| lenSel | input | 3 | Burst length code (see R3) |
| startCol | input | 8 | First column of the burst |
| terminate | input | 1 | Ends the current burst on the next clock |
| colOut | output | 8 | Column address of the current beat |
| colValid | output | 1 | colOut carries a beat this cycle |
| lastBeat | output | 1 | Current beat is the final one of a finite burst |
| errFlag | output | 1 | One-cycle pulse after an illegal start |

## Verification
On every cycle the assertions check the relationships between the strobes. lastBeat only accompanies a valid beat. An error pulse never coincides with a beat and always follows a start. A last beat or a stop, with no new start present, is followed by an idle cycle. Nothing becomes valid without a start. The column values themselves are shown only by the bench scenarios: linear wrap inside an aligned block, XOR ordering, the whole-page wrap through 0xFF, restarts, and the single-beat write override.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  parameter int COL_W   = 8;
  parameter int LEN_W   = 3;
  parameter int MAX_LOG = 3;   // longest finite burst is 2**MAX_LOG
  parameter int FULL_CODE = 7;
  parameter int MIN_IL_LOG = 2;

  typedef struct packed {
    logic             load;
    logic             step;
    logic             xorMode;
    logic [COL_W-1:0] mask;
  } colStrobe_t;
endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             isWrite,
  input  logic             singleWrite,
  input  logic             interleave,
  input  logic [LEN_W-1:0] lenSel,
  input  logic             terminate,
  output colStrobe_t       strobe,
  output logic             colValid,
  output logic             lastBeat,
  output logic             errFlag
);
  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

  logic             forceOne;
  logic             isFull;
  logic             finiteOk;
  logic             legal;
  logic [COL_W-1:0] effMask;
  logic             activeQ;
  logic             fullQ;
  logic             lastQ;
  logic             errQ;
  logic [COL_W-1:0] remainQ;
  logic             moreBeats;

  always_comb begin
    forceOne = singleWrite && isWrite;
    isFull   = (int'(lenSel) == FULL_CODE);
    finiteOk = (int'(lenSel) <= MAX_LOG) &&
               (!interleave || int'(lenSel) >= MIN_IL_LOG);
    legal    = forceOne || finiteOk || (isFull && !interleave);
    if (forceOne)      effMask = '0;
    else if (isFull)   effMask = ALL_ONES;
    else               effMask = (COL_W'(1) << lenSel) - COL_W'(1);
  end

  assign moreBeats = fullQ || (remainQ != '0);

  always_comb begin
    strobe.load    = startIn && legal;
    strobe.step    = !startIn && activeQ && !terminate && moreBeats;
    strobe.xorMode = interleave && !forceOne;
    strobe.mask    = effMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      fullQ   <= 1'b0;
      lastQ   <= 1'b0;
      errQ    <= 1'b0;
      remainQ <= '0;
    end else begin
      errQ <= startIn && !legal;
      if (startIn) begin
        if (legal) begin
          activeQ <= 1'b1;
          fullQ   <= isFull && !forceOne;
          remainQ <= effMask;
          lastQ   <= !(isFull && !forceOne) && (effMask == '0);
        end else begin
          activeQ <= 1'b0;
          lastQ   <= 1'b0;
        end
      end else if (activeQ) begin
        if (terminate || !moreBeats) begin
          activeQ <= 1'b0;
          lastQ   <= 1'b0;
        end else begin
          if (!fullQ) remainQ <= remainQ - COL_W'(1);
          lastQ <= !fullQ && (remainQ == COL_W'(1));
        end
      end
    end
  end

  assign colValid = activeQ;
  assign lastBeat = lastQ && activeQ;
  assign errFlag  = errQ;
endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  colStrobe_t       strobe,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colOut
);
  logic [COL_W-1:0] baseQ;
  logic [COL_W-1:0] maskQ;
  logic             xorQ;
  logic [COL_W-1:0] beatQ;
  logic [COL_W-1:0] colQ;
  logic [COL_W-1:0] beatNext;
  logic [COL_W-1:0] lowPart;
  logic [COL_W-1:0] colNext;

  assign beatNext = beatQ + COL_W'(1);
  assign lowPart  = xorQ ? (baseQ ^ beatNext) : (baseQ + beatNext);

  for (genvar b = 0; b < COL_W; b++) begin : g_merge
    assign colNext[b] = maskQ[b] ? lowPart[b] : baseQ[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      maskQ <= '0;
      xorQ  <= 1'b0;
      beatQ <= '0;
      colQ  <= '0;
    end else if (strobe.load) begin
      baseQ <= startCol;
      maskQ <= strobe.mask;
      xorQ  <= strobe.xorMode;
      beatQ <= '0;
      colQ  <= startCol;
    end else if (strobe.step) begin
      beatQ <= beatNext;
      colQ  <= colNext;
    end
  end

  assign colOut = colQ;
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             isWrite,
  input  logic             singleWrite,
  input  logic             interleave,
  input  logic [LEN_W-1:0] lenSel,
  input  logic [COL_W-1:0] startCol,
  input  logic             terminate,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             lastBeat,
  output logic             errFlag
);
  colStrobe_t strobe;

  burst_col_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .isWrite(isWrite),
    .singleWrite(singleWrite), .interleave(interleave), .lenSel(lenSel),
    .terminate(terminate), .strobe(strobe), .colValid(colValid),
    .lastBeat(lastBeat), .errFlag(errFlag)
  );

  burst_col_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startCol(startCol),
    .colOut(colOut)
  );
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk (
  input logic clk,
  input logic rstN,
  input logic startIn,
  input logic terminate,
  input logic colValid,
  input logic lastBeat,
  input logic errFlag
);
  // R6
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);
  // R8
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !colValid);
  // R8
  err_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> $past(startIn));
  // R6
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && lastBeat && !startIn) |=> !colValid);
  // R7
  stop_ends_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && terminate && !startIn) |=> !colValid);
  // R11
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!colValid && !startIn) |=> !colValid);
endmodule

bind burst_col_gen burst_col_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .terminate(terminate),
  .colValid(colValid), .lastBeat(lastBeat), .errFlag(errFlag)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0;
  logic       isWrite = 1'b0;
  logic       singleWrite = 1'b0;
  logic       interleave = 1'b0;
  logic [2:0] lenSel = 3'd0;
  logic [7:0] startCol = 8'd0;
  logic       terminate = 1'b0;
  logic [7:0] colOut;
  logic       colValid;
  logic       lastBeat;
  logic       errFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  burst_col_gen uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .isWrite(isWrite),
    .singleWrite(singleWrite), .interleave(interleave), .lenSel(lenSel),
    .startCol(startCol), .terminate(terminate), .colOut(colOut),
    .colValid(colValid), .lastBeat(lastBeat), .errFlag(errFlag)
  );

  // {isWrite, singleWrite, interleave, lenSel[2:0], startCol[7:0], beats[3:0], err}
  localparam logic [18:0] VEC [13] = '{
    {1'b0, 1'b0, 1'b0, 3'd0, 8'h37, 4'd1, 1'b0},  // R3 len 1
    {1'b0, 1'b0, 1'b0, 3'd1, 8'h37, 4'd2, 1'b0},  // R3 len 2 wrap
    {1'b0, 1'b0, 1'b0, 3'd2, 8'h37, 4'd4, 1'b0},  // R3 len 4 wrap
    {1'b0, 1'b0, 1'b0, 3'd3, 8'h3D, 4'd8, 1'b0},  // R3 len 8 wrap
    {1'b0, 1'b0, 1'b1, 3'd2, 8'h36, 4'd4, 1'b0},  // R4 xor 4
    {1'b0, 1'b0, 1'b1, 3'd3, 8'h3D, 4'd8, 1'b0},  // R4 xor 8
    {1'b0, 1'b1, 1'b0, 3'd3, 8'h12, 4'd8, 1'b0},  // R9 read keeps length
    {1'b1, 1'b1, 1'b0, 3'd3, 8'h12, 4'd1, 1'b0},  // R9 write single
    {1'b1, 1'b1, 1'b1, 3'd0, 8'hA5, 4'd1, 1'b0},  // R9 override illegal
    {1'b1, 1'b0, 1'b0, 3'd2, 8'hFE, 4'd4, 1'b0},  // R3 write burst
    {1'b0, 1'b0, 1'b0, 3'd5, 8'h10, 4'd0, 1'b1},  // R8 reserved code
    {1'b0, 1'b0, 1'b1, 3'd1, 8'h10, 4'd0, 1'b1},  // R8 xor len 2
    {1'b0, 1'b0, 1'b1, 3'd7, 8'h10, 4'd0, 1'b1}   // R8 xor whole page
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expCol(input logic [7:0] s, input int n,
                                        input bit il, input int k);
    int off = int'(s) % n;
    int base = int'(s) - off;
    return il ? 8'(base + (off ^ k)) : 8'(base + ((off + k) % n));
  endfunction

  task automatic pulseStart(input bit w, input bit sw, input bit il,
                            input logic [2:0] ls, input logic [7:0] sc,
                            input bit term);
    isWrite = w; singleWrite = sw; interleave = il; lenSel = ls;
    startCol = sc; startIn = 1'b1; terminate = term;
    @(negedge clk);
    startIn = 1'b0; terminate = 1'b0;
  endtask

  task automatic expectBeat(input string req, input logic [7:0] col,
                            input bit last);
    check(colValid && colOut == col && lastBeat == last, req, "beat col/last",
          {colValid, lastBeat, colOut}, {1'b1, last, col});
  endtask

  task automatic idleCheck(input string req);
    check(!colValid && !lastBeat, req, "idle after burst",
          {colValid, lastBeat}, 0);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!colValid && !lastBeat && !errFlag && colOut == 8'h00, "R1",
          "reset outputs", {colValid, lastBeat, errFlag, colOut}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R11 idle without a start
    check(!colValid, "R11", "no valid while idle", colValid, 0);

    foreach (VEC[i]) begin
      logic [18:0] v = VEC[i];
      int n = int'(v[4:1]);
      pulseStart(v[18], v[17], v[16], v[15:13], v[12:5], 1'b0);
      if (v[0]) begin
        check(errFlag && !colValid, "R8", "error pulse, no beat",
              {errFlag, colValid}, 2);
        @(negedge clk);
        check(!errFlag && !colValid, "R8", "error lasts one cycle",
              {errFlag, colValid}, 0);
      end else begin
        for (int k = 0; k < n; k++) begin
          expectBeat(k == 0 ? "R2" : (v[16] ? "R4" : "R3"),
                     expCol(v[12:5], n, v[16], k), k == n - 1);
          if (k == n - 1) check(lastBeat, "R6", "last flag", lastBeat, 1);
          @(negedge clk);
        end
        idleCheck("R6");
        check(!errFlag, "R9", "no error on legal start", errFlag, 0);
      end
      @(negedge clk);
    end

    // R5 whole page wraps 0xFF to 0x00, stopped by terminate (R7)
    pulseStart(1'b0, 1'b0, 1'b0, 3'd7, 8'hFC, 1'b0);
    for (int k = 0; k < 8; k++) begin
      expectBeat("R5", 8'(8'hFC + k), 1'b0);
      if (k == 7) terminate = 1'b1;
      @(negedge clk);
    end
    terminate = 1'b0;
    check(!colValid, "R7", "whole page stopped", colValid, 0);
    @(negedge clk);

    // R7 stop in the middle of a finite burst
    pulseStart(1'b0, 1'b0, 1'b0, 3'd3, 8'h40, 1'b0);
    expectBeat("R7", 8'h40, 1'b0);
    @(negedge clk);
    expectBeat("R7", 8'h41, 1'b0);
    terminate = 1'b1;
    @(negedge clk);
    terminate = 1'b0;
    check(!colValid, "R7", "finite burst stopped", colValid, 0);
    @(negedge clk);

    // R10 restart during a burst, start beats terminate
    pulseStart(1'b0, 1'b0, 1'b0, 3'd3, 8'h10, 1'b0);
    expectBeat("R10", 8'h10, 1'b0);
    pulseStart(1'b0, 1'b0, 1'b0, 3'd2, 8'h82, 1'b1);
    expectBeat("R10", 8'h82, 1'b0);
    @(negedge clk);
    expectBeat("R10", 8'h83, 1'b0);
    @(negedge clk);
    expectBeat("R10", 8'h80, 1'b0);
    @(negedge clk);
    expectBeat("R10", 8'h81, 1'b1);
    @(negedge clk);
    idleCheck("R10");
    @(negedge clk);

    // R8 illegal start aborts a running burst
    pulseStart(1'b0, 1'b0, 1'b0, 3'd3, 8'h20, 1'b0);
    expectBeat("R8", 8'h20, 1'b0);
    pulseStart(1'b0, 1'b0, 1'b0, 3'd6, 8'h20, 1'b0);
    check(errFlag && !colValid, "R8", "illegal start aborts burst",
          {errFlag, colValid}, 2);
    repeat (3) @(negedge clk);
    check(!colValid && !errFlag, "R11", "stays idle", {colValid, errFlag}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule